// File: doc/BRIEF.md
# Dual Interval Timer with Limit Compare

This block holds two identical 32-bit interval timers that sit on a processor's auxiliary register bus and run on the core clock. Each timer has a count register, a control register and a limit register. The count rises by one on every enabled cycle. When it equals the limit it returns to zero and keeps running. With the count started at zero and the limit left at all ones, a timer is a free-running 32-bit cycle counter.

A timer can flag an interrupt when its count reaches the limit. The flag is sticky and each arming produces at most one event. Any write to the control register clears the flag and arms the timer again. Software gets oneshot behaviour by leaving the flag alone after an event, and periodic behaviour by rewriting control each time the event arrives. A control bit lets a timer pause while the core reports that it is halted. The bus is a plain register port with no back-pressure. A write completes in the cycle it is presented, and read data is a combinational function of the address and the current register state.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, each timer has count 0, control 0 with no pending flag, and limit 0xFFFFFFFF, and both interrupt outputs are low.
- R2: Timer 0 maps count, control and limit at auxiliary addresses 0x021, 0x022 and 0x023. Timer 1 maps them at 0x100, 0x101 and 0x102. Any other address reads as zero, and a write to it changes no register.
- R3: In a counting cycle where the count differs from the limit and no count write occurs, the count rises by exactly one.
- R4: In a counting cycle where the count equals the limit, the next count is 0. With the limit at all ones, the count therefore goes from 0xFFFFFFFF to 0.
- R5: When control bit 1 is set and the halt input is high, the count holds its value. When bit 1 is clear, the halt input has no effect.
- R6: When control bit 0 is set, a counting cycle in which the count equals the limit sets the pending flag. When bit 0 is clear, reaching the limit leaves the pending flag unchanged.
- R7: The pending flag stays set until a control write clears it. If the limit is reached with bit 0 already set in the same cycle as that write, the flag remains set. Interrupt output i (bit i of the interrupt bus) equals the pending flag of timer i.
- R8: A count write loads the written value at the next clock edge. It takes priority over the increment and the limit compare, so no event occurs in that cycle.
- R9: A limit write is used for every compare from the next cycle on. A count above the limit keeps rising until it passes 0xFFFFFFFF and returns to 0, and no event occurs during that rollover.
- R10: A control read returns bit 0 as interrupt enable, bit 1 as halt gating and bit 3 as the pending flag, with all other bits zero. Written bits other than 0 and 1 are ignored.
- R11: The two timers are independent. Activity on one never changes the registers or the interrupt of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; both timers count on it |
| rst_n | input | 1 | Active-low synchronous reset |
| core_halted | input | 1 | High while the core is halted |
| aux_addr | input | 12 | Auxiliary register address |
| aux_wr | input | 1 | Write strobe for the addressed register |
| aux_wdata | input | 32 | Write data |
| aux_rdata | output | 32 | Read data for aux_addr, combinational |
| timer_irq | output | 2 | Pending interrupt, bit i for timer i |

## Verification
Read data is due in the same cycle as the address. A write, a count step, a wrap and the pending flag are due one clock edge after the cycle that caused them. The interrupt therefore rises in the same cycle in which the wrapped count first reads back as 0. The bench drives inputs at the falling edge and checks a quarter period later. It advances a behavioural model at each rising edge and compares read data and both interrupt bits against that model on every cycle. On top of this it makes fixed-value checks at the cycles worked out above for each corner case: the same-cycle rearm, the rollover above the limit and halt gating.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // register offsets relative to a timer's base address
  localparam int unsigned OFS_COUNT = 0;
  localparam int unsigned OFS_CTRL  = 1;
  localparam int unsigned OFS_LIMIT = 2;

  // control word bit positions
  localparam int unsigned CTL_IE_BIT   = 0;
  localparam int unsigned CTL_GATE_BIT = 1;
  localparam int unsigned CTL_PEND_BIT = 3;

  typedef struct packed {
    logic gate;   // pause while core halted
    logic ie;     // interrupt enable
  } tmr_ctl_t;

  typedef struct packed {
    logic cnt;
    logic ctl;
    logic lim;
  } tmr_sel_t;

endpackage

// File: rtl/timer_aux_decode.sv
module timer_aux_decode
  import timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output tmr_sel_t          sel,
  output tmr_sel_t          we
);

  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(BASE + ADDR_W'(OFS_COUNT));
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(BASE + ADDR_W'(OFS_CTRL));
  localparam logic [ADDR_W-1:0] A_LIM = ADDR_W'(BASE + ADDR_W'(OFS_LIMIT));

  always_comb begin
    sel.cnt = (addr == A_CNT);
    sel.ctl = (addr == A_CTL);
    sel.lim = (addr == A_LIM);
    we.cnt  = wr & sel.cnt;
    we.ctl  = wr & sel.ctl;
    we.lim  = wr & sel.lim;
  end

endmodule

// File: rtl/timer_core.sv
module timer_core
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halted,
  input  tmr_sel_t          we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] ctl_word,
  output logic [DATA_W-1:0] lim,
  output logic              irq
);

  tmr_ctl_t ctl;
  logic     pend;
  logic     run;
  logic     at_lim;
  logic     hit;

  assign run    = !(ctl.gate && halted);
  assign at_lim = (cnt == lim);
  assign hit    = run && !we.cnt && at_lim;

  // count register: write beats increment, wrap at the limit
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (we.cnt) cnt <= wdata;
    else if (hit)    cnt <= '0;
    else if (run)    cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (we.ctl) begin
      ctl.ie   <= wdata[CTL_IE_BIT];
      ctl.gate <= wdata[CTL_GATE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      lim <= '1;
    else if (we.lim) lim <= wdata;
  end

  // sticky pending flag: a control write clears, a hit with enable sets
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend && !we.ctl) || (hit && ctl.ie);
  end

  always_comb begin
    ctl_word               = '0;
    ctl_word[CTL_IE_BIT]   = ctl.ie;
    ctl_word[CTL_GATE_BIT] = ctl.gate;
    ctl_word[CTL_PEND_BIT] = pend;
  end

  assign irq = pend;

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !we.cnt && !at_lim) |=> (cnt == ($past(cnt) + 1'b1)));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !we.cnt && at_lim) |=> (cnt == '0));

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.gate && halted && !we.cnt) |=> $stable(cnt));

  // R6
  pend_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctl.ie));

  // R7
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !we.ctl) |=> irq);

  // R8
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we.cnt |=> (cnt == $past(wdata)));

endmodule

// File: rtl/timer_read_mux.sv
module timer_read_mux
  import timer_pkg::*;
#(
  parameter int unsigned N      = 2,
  parameter int unsigned DATA_W = 32
) (
  input  tmr_sel_t [N-1:0]             sel,
  input  logic     [N-1:0][DATA_W-1:0] cnt,
  input  logic     [N-1:0][DATA_W-1:0] ctl_word,
  input  logic     [N-1:0][DATA_W-1:0] lim,
  output logic            [DATA_W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i].cnt) rdata = rdata | cnt[i];
      if (sel[i].ctl) rdata = rdata | ctl_word[i];
      if (sel[i].lim) rdata = rdata | lim[i];
    end
  end

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter logic [ADDR_W-1:0] T0_BASE = 12'h021,
  parameter logic [ADDR_W-1:0] T1_BASE = 12'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_halted,
  input  logic [ADDR_W-1:0] aux_addr,
  input  logic              aux_wr,
  input  logic [DATA_W-1:0] aux_wdata,
  output logic [DATA_W-1:0] aux_rdata,
  output logic [1:0]        timer_irq
);

  localparam int unsigned NT = 2;

  tmr_sel_t [NT-1:0]             sel;
  tmr_sel_t [NT-1:0]             we;
  logic     [NT-1:0][DATA_W-1:0] cnt;
  logic     [NT-1:0][DATA_W-1:0] ctl_word;
  logic     [NT-1:0][DATA_W-1:0] lim;

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    localparam logic [ADDR_W-1:0] BASE = (g == 0) ? T0_BASE : T1_BASE;

    timer_aux_decode #(
      .ADDR_W (ADDR_W),
      .BASE   (BASE)
    ) u_dec (
      .addr (aux_addr),
      .wr   (aux_wr),
      .sel  (sel[g]),
      .we   (we[g])
    );

    timer_core #(
      .DATA_W (DATA_W)
    ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .halted   (core_halted),
      .we       (we[g]),
      .wdata    (aux_wdata),
      .cnt      (cnt[g]),
      .ctl_word (ctl_word[g]),
      .lim      (lim[g]),
      .irq      (timer_irq[g])
    );
  end

  timer_read_mux #(
    .N      (NT),
    .DATA_W (DATA_W)
  ) u_rmux (
    .sel      (sel),
    .cnt      (cnt),
    .ctl_word (ctl_word),
    .lim      (lim),
    .rdata    (aux_rdata)
  );

  // R2
  one_reg_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel[1].cnt, sel[1].ctl, sel[1].lim,
              sel[0].cnt, sel[0].ctl, sel[0].lim}));

  // R11
  other_limit_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_wr && !we[1].lim) |=> (lim[1] == $past(lim[1])));

endmodule

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        core_halted;
  logic [11:0] aux_addr;
  logic        aux_wr;
  logic [31:0] aux_wdata;
  logic [31:0] aux_rdata;
  logic [1:0]  timer_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dual_interval_timer u_dual_interval_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_halted (core_halted),
    .aux_addr    (aux_addr),
    .aux_wr      (aux_wr),
    .aux_wdata   (aux_wdata),
    .aux_rdata   (aux_rdata),
    .timer_irq   (timer_irq)
  );

  // behavioural reference state
  logic [31:0] m_cnt  [2];
  logic [1:0]  m_ctl  [2];
  logic        m_pend [2];
  logic [31:0] m_lim  [2];

  function automatic logic [11:0] base_of(int t);
    return (t == 0) ? 12'h021 : 12'h100;
  endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a);
    for (int t = 0; t < 2; t++) begin
      if (a == base_of(t))      return m_cnt[t];
      if (a == base_of(t) + 1)  return {28'd0, m_pend[t], 1'b0, m_ctl[t]};
      if (a == base_of(t) + 2)  return m_lim[t];
    end
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    for (int t = 0; t < 2; t++) begin
      if (!rst_n) begin
        m_cnt[t] = 0; m_ctl[t] = 0; m_pend[t] = 0; m_lim[t] = 32'hFFFF_FFFF;
      end else begin
        bit run, wc, wt, wl, lim_hit;
        run = !(m_ctl[t][1] && core_halted);
        wc  = aux_wr && aux_addr == base_of(t);
        wt  = aux_wr && aux_addr == base_of(t) + 1;
        wl  = aux_wr && aux_addr == base_of(t) + 2;
        lim_hit = run && !wc && (m_cnt[t] == m_lim[t]);
        m_pend[t] = (m_pend[t] && !wt) || (lim_hit && m_ctl[t][0]);
        if (wc)           m_cnt[t] = aux_wdata;
        else if (lim_hit) m_cnt[t] = 0;
        else if (run)     m_cnt[t] = m_cnt[t] + 1;
        if (wt) m_ctl[t] = aux_wdata[1:0];
        if (wl) m_lim[t] = aux_wdata;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every cycle, a quarter period after the fall
  always @(negedge clk) begin
    #(CLK_P/4);
    if (rst_n === 1'b1 && !done) begin
      chk("R2 read vs model", aux_rdata, exp_read(aux_addr));
      chk("R7 irq vs model", {30'd0, timer_irq}, {30'd0, m_pend[1], m_pend[0]});
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    aux_addr = a; aux_wr = 1'b1; aux_wdata = d;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    aux_addr = a; aux_wr = 1'b0;
    #(CLK_P/4);
    v = aux_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      aux_wr = 1'b0;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    rst_n = 1'b0; core_halted = 1'b0; aux_addr = '0; aux_wr = 1'b0; aux_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h023, v); chk("R1 t0 limit", v, 32'hFFFF_FFFF);
    rd(12'h022, v); chk("R1 t0 ctrl", v, 32'd0);
    rd(12'h101, v); chk("R1 t1 ctrl", v, 32'd0);
    chk("R1 irq low", {30'd0, timer_irq}, 32'd0);

    // R8 load, R3 increment
    wr(12'h021, 32'd100);
    rd(12'h021, v); chk("R8 count load", v, 32'd100);
    rd(12'h021, v); chk("R3 count step", v, 32'd101);

    // R4 free-run rollover with interrupt disabled
    wr(12'h021, 32'hFFFF_FFFE);
    rd(12'h021, v); chk("R4 pre wrap", v, 32'hFFFF_FFFE);
    rd(12'h021, v); chk("R4 at limit", v, 32'hFFFF_FFFF);
    rd(12'h021, v); chk("R4 wrapped", v, 32'd0);
    chk("R6 no irq when disabled", {31'd0, timer_irq[0]}, 32'd0);

    // R6 event with enable, R10 control format
    wr(12'h023, 32'd5);
    wr(12'h022, 32'd1);
    wr(12'h021, 32'd0);
    idle(8);
    chk("R6 irq set", {31'd0, timer_irq[0]}, 32'd1);
    rd(12'h022, v); chk("R10 ctrl with pending", v, 32'd9);
    idle(10);
    chk("R7 sticky", {31'd0, timer_irq[0]}, 32'd1);

    // R7 clear by control write, then same-cycle rearm keeps the flag
    wr(12'h021, 32'd0);
    wr(12'h022, 32'd1);
    idle(1);
    chk("R7 cleared", {31'd0, timer_irq[0]}, 32'd0);
    wr(12'h021, 32'd5);
    wr(12'h022, 32'd1);
    idle(1);
    chk("R7 hit beats clear", {31'd0, timer_irq[0]}, 32'd1);

    // R9 count above limit rolls over without an event
    wr(12'h021, 32'hFFFF_FFF0);
    wr(12'h022, 32'd1);
    idle(12);
    chk("R9 no event above limit", {31'd0, timer_irq[0]}, 32'd0);
    idle(6);
    rd(12'h021, v); chk("R9 count after rollover", v, exp_read(12'h021));
    wr(12'h023, 32'd40);
    rd(12'h023, v); chk("R9 limit written", v, 32'd40);

    // R5 halt gating
    wr(12'h022, 32'd2);
    core_halted = 1'b1;
    rd(12'h021, v);
    rd(12'h021, v2); chk("R5 hold while halted", v2, v);
    wr(12'h022, 32'd0);
    rd(12'h021, v);
    rd(12'h021, v2); chk("R5 halt ignored", v2, v + 32'd1);
    core_halted = 1'b0;

    // R2 unmapped addresses
    wr(12'h024, 32'h1234_5678);
    wr(12'h103, 32'h0000_0001);
    rd(12'h024, v); chk("R2 unmapped reads zero", v, 32'd0);
    rd(12'h020, v); chk("R2 unmapped low", v, 32'd0);
    rd(12'h023, v); chk("R2 limit untouched", v, 32'd40);
    rd(12'h102, v); chk("R2 t1 limit untouched", v, 32'hFFFF_FFFF);

    // R10 upper control bits ignored
    wr(12'h022, 32'hFFFF_FFF4);
    rd(12'h022, v); chk("R10 ignored bits", v, 32'd0);

    // R11 timer 1 alone
    wr(12'h102, 32'd3);
    wr(12'h101, 32'd1);
    wr(12'h100, 32'd0);
    idle(6);
    chk("R11 t1 irq", {31'd0, timer_irq[1]}, 32'd1);
    chk("R11 t0 quiet", {31'd0, timer_irq[0]}, 32'd0);
    rd(12'h101, v); chk("R11 t1 ctrl", v, 32'd9);
    rd(12'h023, v); chk("R11 t0 limit kept", v, 32'd40);

    idle(2);
    finish_run();
  end

endmodule